// File: doc/BRIEF.md
# Configuration Port Contention Controller

This block is the logic an adapter card needs behind a write-only configuration port that every card on the bus shares. It watches byte writes to the port. Before it will respond to anything, the host has to write a pair of zero bytes and then the full 255-byte unlock pattern. An 8-bit shift-and-xor rule generates that pattern, and the block recomputes it one byte at a time as the bytes arrive.

Once unlocked, the block decodes single-byte commands. A read command fetches one 16-bit word from a small word-addressed configuration memory. The block then returns that word one bit per read strobe, most significant bit first. Other commands set or clear a tag that makes the card deaf to later read commands, raise a sticky activation output, or issue a global reset.

The FSM has four states. ST_IDLE waits for the zero pair. ST_MATCH compares each byte against the expected pattern byte. ST_CMD decodes commands. ST_FETCH lasts one cycle and captures the memory word.

The transitions are:
- zero pair: from IDLE, MATCH or CMD to MATCH.
- mismatch: from MATCH to IDLE.
- last match: from MATCH to CMD.
- read command: from CMD to FETCH.
- fetch done: from FETCH to CMD.
- global reset: from CMD to IDLE.

Top module: `idp_contention`

## Requirements
- R1: After reset the block is in ST_IDLE, and active, greset, cfg_rd and rd_bit are all 0.
- R2: Two consecutive accepted writes of 0x00 restart the pattern checker from any state. Idle cycles between the two writes are allowed. The next expected byte is then 0xFF. Tag and active are kept.
- R3: Each expected byte after 0xFF comes from the previous one. Shift it left by one bit. If the bit shifted out was 1, xor the result with 0xCF. The block enters command state only after 255 bytes have matched in a row, and command bytes have no effect before that.
- R4: A byte that does not match the expected byte returns the block to ST_IDLE. Command bytes are then ignored until the block is unlocked again.
- R5: In command state, a write of 0x80 to 0xBF is a read command, and its low 6 bits are the word offset. In the next cycle cfg_rd is high for exactly one cycle, with cfg_addr equal to the offset. The word on cfg_data is captured in that cycle, and writes made during that cycle are dropped.
- R6: rd_bit shows the current bit of the captured word, starting with bit 15. Each rd_en advances to the next lower bit. After 16 advances, rd_bit reads 0.
- R7: A new read command reloads the word and restarts the bit count, even when part of the previous word is still unread.
- R8: Command 0xD1 sets the tag. While the tag is set, read commands start no fetch and leave rd_bit unchanged. Command 0xD0 clears the tag.
- R9: Command 0xFF sets active to 1, and active stays 1 until a global reset.
- R10: Command 0xC0 raises greset for exactly one cycle, starting the cycle after the write. It also clears active, the tag and the unread bits, and returns the block to ST_IDLE.
- R11: An rd_en in the same cycle as a read-command write advances the old word. An rd_en during the fetch cycle is ignored, so after a fetch the reload wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe to the shared port |
| wr_data | input | 8 | Byte written |
| rd_en | input | 1 | Read strobe, advances the serial bit |
| rd_bit | output | 1 | Current serial data bit (bit 0 of read data) |
| cfg_rd | output | 1 | Configuration memory read strobe |
| cfg_addr | output | 6 | Configuration memory word address |
| cfg_data | input | WORD_W | Configuration memory word, valid while cfg_rd is high |
| active | output | 1 | Card activated |
| greset | output | 1 | One-cycle global reset pulse |

## Verification
The two functions that can fall in the same cycle are the serial shift-out and the word reload that a read command starts. The bench provokes this in two ways. First, it asserts rd_en in the cycle that carries a new read command. Second, it asserts rd_en again in the following fetch cycle. It then judges the result by whether the first bit shown afterwards is the top bit of the newly fetched word. A behavioural reference model, compared every cycle, also catches any one-cycle slip in the strobe, pulse or bit outputs.

// File: rtl/idp_pkg.sv
package idp_pkg;

    localparam int CFG_ADDR_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_CMD   = 2'd2,
        ST_FETCH = 2'd3
    } idp_state_e;

    localparam logic [7:0] CODE_UNTAG  = 8'hD0;
    localparam logic [7:0] CODE_TAG    = 8'hD1;
    localparam logic [7:0] CODE_ACT    = 8'hFF;
    localparam logic [7:0] CODE_GRESET = 8'hC0;

    typedef struct packed {
        logic                  is_read;
        logic [CFG_ADDR_W-1:0] offset;
        logic                  is_tag;
        logic                  is_untag;
        logic                  is_act;
        logic                  is_grst;
    } idp_cmd_t;

endpackage

// File: rtl/idp_seq_gen.sv
module idp_seq_gen #(
    parameter int         SEQ_LEN = 255,
    parameter logic [7:0] SEED    = 8'hFF,
    parameter logic [7:0] TAPS    = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] exp_byte,
    output logic       last
);
    localparam int IDX_W = $clog2(SEQ_LEN);

    logic [7:0]       exp_q;
    logic [7:0]       exp_next;
    logic [IDX_W-1:0] idx_q;

    assign exp_next[0] = TAPS[0] & exp_q[7];
    for (genvar i = 1; i < 8; i++) begin : g_tap
        assign exp_next[i] = exp_q[i-1] ^ (TAPS[i] & exp_q[7]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            exp_q <= SEED;
            idx_q <= '0;
        end else if (advance) begin
            exp_q <= exp_next;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign exp_byte = exp_q;
    assign last     = (idx_q == IDX_W'(SEQ_LEN - 1));
endmodule

// File: rtl/idp_cmd_decode.sv
module idp_cmd_decode
    import idp_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output idp_cmd_t   cmd
);
    always_comb begin
        cmd          = '0;
        cmd.is_read  = (cmd_byte[7:6] == 2'b10);
        cmd.offset   = cmd_byte[CFG_ADDR_W-1:0];
        cmd.is_tag   = (cmd_byte == CODE_TAG);
        cmd.is_untag = (cmd_byte == CODE_UNTAG);
        cmd.is_act   = (cmd_byte == CODE_ACT);
        cmd.is_grst  = (cmd_byte == CODE_GRESET);
    end
endmodule

// File: rtl/idp_bit_shifter.sv
module idp_bit_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              bit_out
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word_q <= '0;
            left_q <= '0;
        end else if (load) begin
            word_q <= load_word;
            left_q <= CNT_W'(WORD_W);
        end else if (shift && left_q != '0) begin
            word_q <= {word_q[WORD_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    assign bit_out = (left_q != '0) & word_q[WORD_W-1];
endmodule

// File: rtl/idp_contention.sv
module idp_contention
    import idp_pkg::*;
#(
    parameter int         WORD_W  = 16,
    parameter int         SEQ_LEN = 255,
    parameter logic [7:0] SEED    = 8'hFF,
    parameter logic [7:0] TAPS    = 8'hCF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    output logic                  rd_bit,
    output logic                  cfg_rd,
    output logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [WORD_W-1:0]     cfg_data,
    output logic                  active,
    output logic                  greset
);
    idp_state_e state_q, state_d;

    logic                  zero_q;
    logic                  tag_q;
    logic                  active_q;
    logic                  greset_q;
    logic [CFG_ADDR_W-1:0] addr_q;

    idp_cmd_t   cmd;
    logic [7:0] exp_byte;
    logic       seq_last;

    logic wr_live, pair_zero, byte_ok, cmd_wr, do_read, do_grst, seq_adv;

    // Writes are accepted in every state but the one-cycle fetch.
    assign wr_live   = wr_en && (state_q != ST_FETCH);
    assign pair_zero = wr_live && (wr_data == 8'h00) && zero_q;
    assign byte_ok   = (wr_data == exp_byte);
    assign cmd_wr    = wr_live && !pair_zero && (state_q == ST_CMD);
    assign do_read   = cmd_wr && cmd.is_read && !tag_q;
    assign do_grst   = cmd_wr && cmd.is_grst;
    assign seq_adv   = wr_live && !pair_zero && (state_q == ST_MATCH) && byte_ok;

    idp_cmd_decode u_dec (
        .cmd_byte (wr_data),
        .cmd      (cmd)
    );

    idp_seq_gen #(
        .SEQ_LEN (SEQ_LEN),
        .SEED    (SEED),
        .TAPS    (TAPS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (pair_zero),
        .advance  (seq_adv),
        .exp_byte (exp_byte),
        .last     (seq_last)
    );

    idp_bit_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_grst),
        .load      (state_q == ST_FETCH),
        .load_word (cfg_data),
        .shift     (rd_en && (state_q != ST_FETCH)),
        .bit_out   (rd_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pair_zero) state_d = ST_MATCH;
            end
            ST_MATCH: begin
                if (pair_zero)                state_d = ST_MATCH;
                else if (wr_live && !byte_ok) state_d = ST_IDLE;
                else if (seq_adv && seq_last) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (pair_zero)    state_d = ST_MATCH;
                else if (do_grst) state_d = ST_IDLE;
                else if (do_read) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                state_d = ST_CMD;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q   <= 1'b0;
            tag_q    <= 1'b0;
            active_q <= 1'b0;
            greset_q <= 1'b0;
            addr_q   <= '0;
        end else begin
            greset_q <= do_grst;
            if (wr_live) zero_q <= (wr_data == 8'h00);
            if (do_read) addr_q <= cmd.offset;
            if (do_grst) begin
                tag_q    <= 1'b0;
                active_q <= 1'b0;
            end else if (cmd_wr) begin
                if (cmd.is_tag)   tag_q    <= 1'b1;
                if (cmd.is_untag) tag_q    <= 1'b0;
                if (cmd.is_act)   active_q <= 1'b1;
            end
        end
    end

    assign cfg_rd   = (state_q == ST_FETCH);
    assign cfg_addr = addr_q;
    assign active   = active_q;
    assign greset   = greset_q;
endmodule

// File: rtl/idp_contention_chk.sv
module idp_contention_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       cfg_rd,
    input logic [5:0] cfg_addr,
    input logic       active,
    input logic       greset,
    input logic       tag
);
    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |=> !cfg_rd); // R5

    AST_FETCH_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |-> ($past(wr_en) && $past(wr_data[7:6]) == 2'b10)); // R5

    AST_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |-> (cfg_addr == $past(wr_data[5:0]))); // R5

    AST_FETCH_UNTAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd |-> !$past(tag)); // R8

    AST_ACTIVE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($past(wr_en) && $past(wr_data) == 8'hFF)); // R9

    AST_ACTIVE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> greset); // R9

    AST_GRESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        greset |=> !greset); // R10

    AST_GRESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        greset |-> ($past(wr_en) && $past(wr_data) == 8'hC0 && !active && !tag)); // R10
endmodule

bind idp_contention idp_contention_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_rd   (cfg_rd),
    .cfg_addr (cfg_addr),
    .active   (active),
    .greset   (greset),
    .tag      (tag_q)
);

// File: tb/idp_contention_tb.sv
module idp_contention_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_en = 1'b0;
    logic        rd_bit, cfg_rd, active, greset;
    logic [5:0]  cfg_addr;
    logic [15:0] cfg_data;
    logic [15:0] mem [64];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    initial for (int i = 0; i < 64; i++) mem[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
    assign cfg_data = mem[cfg_addr];

    idp_contention dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_bit(rd_bit), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .active(active), .greset(greset)
    );

    function automatic logic [7:0] nxt(logic [7:0] b);
        return b[7] ? ((b << 1) ^ 8'hCF) : (b << 1);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model: 0 idle, 1 matching, 2 command
    int          m_mode = 0;
    bit          m_zero = 0, m_tag = 0, m_act = 0, m_gr = 0, m_fetch = 0;
    int          m_cnt = 0, m_bits = 0;
    logic [7:0]  m_exp = 8'hFF;
    logic [5:0]  m_addr = 0;
    logic [15:0] m_word = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_zero = 0; m_tag = 0; m_act = 0; m_gr = 0;
            m_fetch = 0; m_bits = 0; m_word = 0; m_addr = 0;
        end else begin
            m_gr = 0;
            if (m_fetch) begin
                m_word = mem[m_addr]; m_bits = 16; m_fetch = 0;
            end else begin
                if (rd_en && m_bits > 0) begin m_word = m_word << 1; m_bits--; end
                if (wr_en) begin
                    if (wr_data == 0 && m_zero) begin
                        m_mode = 1; m_exp = 8'hFF; m_cnt = 0;
                    end else begin
                        m_zero = (wr_data == 0);
                        if (m_mode == 1) begin
                            if (wr_data == m_exp) begin
                                m_cnt++; m_exp = nxt(m_exp);
                                if (m_cnt == 255) m_mode = 2;
                            end else m_mode = 0;
                        end else if (m_mode == 2) begin
                            if (wr_data[7:6] == 2'b10 && !m_tag) begin
                                m_fetch = 1; m_addr = wr_data[5:0];
                            end else if (wr_data == 8'hC0) begin
                                m_act = 0; m_tag = 0; m_gr = 1; m_mode = 0; m_bits = 0;
                            end else if (wr_data == 8'hD0) m_tag = 0;
                            else if (wr_data == 8'hD1) m_tag = 1;
                            else if (wr_data == 8'hFF) m_act = 1;
                        end
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 rd_bit", int'(rd_bit), int'(m_bits > 0 && m_word[15]));
            check("R5 cfg_rd", int'(cfg_rd), int'(m_fetch));
            if (m_fetch) check("R5 cfg_addr", int'(cfg_addr), int'(m_addr));
            check("R9 active", int'(active), int'(m_act));
            check("R10 greset", int'(greset), int'(m_gr));
        end
    end

    task automatic cyc(bit w, logic [7:0] d, bit r);
        wr_en = w; wr_data = d; rd_en = r;
        @(negedge clk); #1;
        wr_en = 0; rd_en = 0;
    endtask

    task automatic wr(logic [7:0] d); cyc(1, d, 0); endtask
    task automatic rd(); cyc(0, 8'h00, 1); endtask

    task automatic unlock(int n);
        logic [7:0] b = 8'hFF;
        wr(8'h00); wr(8'h00);
        for (int i = 0; i < n; i++) begin wr(b); b = nxt(b); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 active", int'(active), 0);
        check("R1 greset", int'(greset), 0);
        check("R1 cfg_rd", int'(cfg_rd), 0);
        check("R1 rd_bit", int'(rd_bit), 0);
        rst_n = 1;
        @(negedge clk); #1;
        // R1: idle after reset, so commands do nothing
        wr(8'hFF);
        check("R1 idle ignores activate", int'(active), 0);

        // R3: partial pattern, then a command byte
        unlock(100);
        wr(8'hFF);
        check("R3 command before unlock", int'(active), 0);
        // R4: after mismatch, read command must not fetch
        wr(8'h87);
        check("R4 no fetch after mismatch", int'(cfg_rd), 0);

        // Full unlock, read word at offset 7
        unlock(255);
        wr(8'h87);
        check("R5 fetch strobe", int'(cfg_rd), 1);
        check("R5 fetch address", int'(cfg_addr), 7);
        @(negedge clk); #1;
        for (int i = 15; i >= 0; i--) begin
            check("R6 serial bit", int'(rd_bit), int'(mem[7][i]));
            rd();
        end
        check("R6 past end reads 0", int'(rd_bit), 0);
        rd();
        check("R6 past end stays 0", int'(rd_bit), 0);

        // R7: reload mid-word
        wr(8'h88); @(negedge clk); #1;
        repeat (5) rd();
        wr(8'h85); @(negedge clk); #1;
        check("R7 reload first bit", int'(rd_bit), int'(mem[5][15]));
        rd();
        check("R7 reload second bit", int'(rd_bit), int'(mem[5][14]));

        // R11: rd_en with command write, then rd_en during fetch
        cyc(1, 8'h83, 1);
        check("R11 fetch follows", int'(cfg_rd), 1);
        rd();
        check("R11 reload wins", int'(rd_bit), int'(mem[3][15]));
        rd();
        check("R11 next bit", int'(rd_bit), int'(mem[3][14]));

        // R5: write during fetch is dropped
        wr(8'h84);
        wr(8'hFF);
        check("R5 write in fetch dropped", int'(active), 0);

        // R8: tag blocks reads
        wr(8'h90); @(negedge clk); #1;
        rd(); rd();
        wr(8'hD1);
        wr(8'h89);
        check("R8 tagged no fetch", int'(cfg_rd), 0);
        check("R8 tagged bit unchanged", int'(rd_bit), int'(mem[16][13]));
        wr(8'hD0);
        wr(8'h89);
        check("R8 untag fetch", int'(cfg_rd), 1);
        @(negedge clk); #1;

        // R9: activate is sticky
        wr(8'hFF);
        check("R9 active set", int'(active), 1);
        wr(8'hD1); wr(8'hD0); wr(8'h12);
        check("R9 active held", int'(active), 1);

        // R2: zero pair in command state restarts checker
        wr(8'h00); wr(8'h00);
        wr(8'h87);
        check("R2 restart leaves command state", int'(cfg_rd), 0);
        check("R2 active kept", int'(active), 1);
        unlock(255);
        wr(8'h81);
        check("R2 re-unlock fetch", int'(cfg_rd), 1);
        @(negedge clk); #1;

        // R10: global reset
        wr(8'hC0);
        check("R10 greset pulse", int'(greset), 1);
        check("R10 active cleared", int'(active), 0);
        check("R10 bits cleared", int'(rd_bit), 0);
        @(negedge clk); #1;
        check("R10 pulse one cycle", int'(greset), 0);
        wr(8'h87);
        check("R10 back to idle", int'(cfg_rd), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule